// File: doc/BRIEF.md
# Fixed-Latency Interrupt Entry Controller

This block steers an 8-bit processor core into its interrupt vector after a fixed number of instruction cycles. It runs a four-phase instruction-cycle counter and reports the current phase to the core. It accepts two interrupt sources. The internal source is already aligned to the core clock. The external source is asynchronous: it passes through a flop synchroniser and an edge detector before it can be used. Requests are only recognised on the first clock of an instruction cycle, and only while the global interrupt enable is set and no interrupt is in progress.

When a request is recognised, the block saves the core's working register, status register and bank register into shadow storage, with no software action needed, and it clears the global enable. It then strobes a return-address push one instruction cycle later and strobes the vector load three instruction cycles after recognition. A return-from-interrupt strobe from the core does three things:
- it sets the global enable again;
- it ends the service period;
- one clock later it presents all three saved registers together with a single restore strobe.

A request that arrives while the enable is off, or while an interrupt is in progress, is held pending and taken afterwards.

Top module: `irq_entry_ctrl`

## Requirements
- R1: While reset is asserted, the following outputs are all 0: gie, vec_load, ret_push, rest_load, the three restored-state outputs and cyc_phase.
- R2: After reset is released, cyc_phase advances by one on every clock and wraps from 3 to 0. Phase 0 marks the first clock of an instruction cycle.
- R3: Assume gie=1, the block is idle, and int_irq is high in a clock whose cyc_phase is 0. Then vec_load is high for exactly one clock, 12 clocks later, in a phase-0 clock.
- R4: ret_push is high for exactly one clock, 4 clocks after the clock in which the request was recognised. It is therefore 8 clocks before vec_load.
- R5: A rising level on ext_irq is detected through a two-flop synchroniser. Measured from the clock edge at which the second flop first holds the high level, vec_load follows after 12, 13, 14 or 15 clocks, depending on the phase at that point. An ext_irq level that stays high causes only one entry.
- R6: Recognising a request clears gie. If a request arrives while gie is 0, it is held pending. It is then taken at the first phase-0 clock after gie has been written to 1, and vec_load follows 12 clocks after that clock.
- R7: In the clock where a request is recognised, the block saves core_w, core_status and core_bsr. Changes to these inputs after that clock have no effect on the saved values.
- R8: reti is acted on only after the vector load, while the interrupt is in service. In that case gie is 1 on the next clock, and in that same next clock rest_load is high for one clock, with all three saved values on rest_w, rest_status and rest_bsr. A reti at any other time changes nothing.
- R9: A request that arrives while an interrupt is in service stays pending. It is taken at the first phase-0 clock after the clock in which reti was accepted.
- R10: Suppose int_irq is high in a clock whose phase p is not 0. The request is held and recognised at the next phase-0 clock, so vec_load follows 12 + (4 - p) clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_irq | input | 1 | Asynchronous external request level |
| int_irq | input | 1 | Synchronous internal request |
| gie_we | input | 1 | Write strobe for the global enable |
| gie_wdata | input | 1 | Value written to the global enable |
| reti | input | 1 | Return-from-interrupt strobe from the core |
| core_w | input | 8 | Live working register of the core |
| core_status | input | 8 | Live status register of the core |
| core_bsr | input | 8 | Live bank select register of the core |
| cyc_phase | output | 2 | Current phase within the instruction cycle |
| gie | output | 1 | Global interrupt enable |
| vec_load | output | 1 | Load the interrupt vector into the program counter |
| ret_push | output | 1 | Push the return address |
| rest_load | output | 1 | Restore strobe for the three shadowed registers |
| rest_w | output | 8 | Saved working register |
| rest_status | output | 8 | Saved status register |
| rest_bsr | output | 8 | Saved bank select register |

## Verification
The bench measures latency in clocks for an internal request raised in each of the four phases, and for an external edge raised in each of the four phases. A design that recognised requests mid-cycle, or added an extra register on the internal path, would be off by a clock or more. A synchroniser that is one stage short or one stage too deep shifts every external latency by one clock. A held external level that retriggers after return shows up as a second vector load.

The bench changes the core registers right after entry. A shadow that captured late would then restore the wrong values. Requests are also raised while the enable is off and during service; a design that dropped these requests instead of holding them would never enter again. A stray reti while idle must neither set the enable nor pulse the restore strobe.

// File: rtl/irqe_pkg.sv
package irqe_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_ENTRY = 2'd1,
      SEQ_SERVE = 2'd2
   } irqe_seq_e;

   function automatic int unsigned irqe_clocks(input int unsigned cycles,
                                               input int unsigned phases);
      return cycles * phases;
   endfunction

endpackage

// File: rtl/irqe_phase_gen.sv
module irqe_phase_gen #(
   parameter int unsigned PHASES = 4,
   parameter int unsigned PH_W   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [PH_W-1:0] phase,
   output logic            cyc_start
);

   localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

   logic [PH_W-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               phase_q <= '0;
      else if (phase_q == LAST) phase_q <= '0;
      else                      phase_q <= phase_q + PH_W'(1);
   end

   assign phase     = phase_q;
   assign cyc_start = (phase_q == '0);

   a_r2_phase_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != LAST) |=> (phase_q == $past(phase_q) + PH_W'(1)));

   a_r2_phase_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == LAST) |=> (phase_q == '0));

endmodule

// File: rtl/irqe_ext_sync.sv
module irqe_ext_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_in};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise = sync_q[STAGES-1] & ~prev_q;

   a_r5_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/irqe_shadow.sv
module irqe_shadow #(
   parameter int unsigned DW   = 8,
   parameter int unsigned NREG = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               save,
   input  logic [NREG*DW-1:0] live,
   output logic [NREG*DW-1:0] saved
);

   logic [DW-1:0] bank_q [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    bank_q[g] <= '0;
         else if (save) bank_q[g] <= live[g*DW +: DW];
      end
      assign saved[g*DW +: DW] = bank_q[g];

      a_r7_slot_captures: assert property (@(posedge clk) disable iff (!rst_n)
         save |=> (saved[g*DW +: DW] == $past(live[g*DW +: DW])));
   end

endmodule

// File: rtl/irqe_entry_seq.sv
module irqe_entry_seq
   import irqe_pkg::*;
#(
   parameter int unsigned VEC_CLK  = 12,
   parameter int unsigned PUSH_CLK = 4,
   parameter int unsigned CW       = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_start,
   input  logic int_irq,
   input  logic ext_rise,
   input  logic gie_we,
   input  logic gie_wdata,
   input  logic reti,
   output logic save,
   output logic gie,
   output logic vec_load,
   output logic ret_push,
   output logic rest_load
);

   irqe_seq_e     state_q;
   logic [CW-1:0] cnt_q;
   logic          int_pend_q, ext_pend_q, gie_q, rest_q;
   logic          any_req, take, reti_ok;

   always_comb begin
      any_req = int_irq | int_pend_q | ext_rise | ext_pend_q;
      take    = (state_q == SEQ_IDLE) && cyc_start && gie_q && any_req;
      reti_ok = reti && (state_q == SEQ_SERVE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SEQ_IDLE;
         cnt_q      <= '0;
         int_pend_q <= 1'b0;
         ext_pend_q <= 1'b0;
         gie_q      <= 1'b0;
         rest_q     <= 1'b0;
      end else begin
         rest_q <= reti_ok;
         if (take) begin
            int_pend_q <= 1'b0;
            ext_pend_q <= 1'b0;
         end else begin
            int_pend_q <= int_pend_q | int_irq;
            ext_pend_q <= ext_pend_q | ext_rise;
         end
         if (take)         gie_q <= 1'b0;
         else if (reti_ok) gie_q <= 1'b1;
         else if (gie_we)  gie_q <= gie_wdata;
         unique case (state_q)
            SEQ_IDLE: begin
               if (take) begin
                  state_q <= SEQ_ENTRY;
                  cnt_q   <= CW'(1);
               end
            end
            SEQ_ENTRY: begin
               if (cnt_q == CW'(VEC_CLK)) begin
                  state_q <= SEQ_SERVE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            SEQ_SERVE: begin
               if (reti_ok) state_q <= SEQ_IDLE;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign save      = take;
   assign gie       = gie_q;
   assign vec_load  = (state_q == SEQ_ENTRY) && (cnt_q == CW'(VEC_CLK));
   assign ret_push  = (state_q == SEQ_ENTRY) && (cnt_q == CW'(PUSH_CLK));
   assign rest_load = rest_q;

   a_r3_vec_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      vec_load |-> cyc_start);

   a_r3_vec_single: assert property (@(posedge clk) disable iff (!rst_n)
      vec_load |=> !vec_load);

   a_r4_push_single: assert property (@(posedge clk) disable iff (!rst_n)
      ret_push |=> (!ret_push && !vec_load));

   a_r6_take_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
      save |=> !gie);

   a_r8_restore_after_reti: assert property (@(posedge clk) disable iff (!rst_n)
      rest_load |-> ($past(reti) && gie));

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
   import irqe_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned PHASES      = 4,
   parameter int unsigned LAT_CYC     = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PH_W        = $clog2(PHASES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_irq,
   input  logic              int_irq,
   input  logic              gie_we,
   input  logic              gie_wdata,
   input  logic              reti,
   input  logic [DATA_W-1:0] core_w,
   input  logic [DATA_W-1:0] core_status,
   input  logic [DATA_W-1:0] core_bsr,
   output logic [PH_W-1:0]   cyc_phase,
   output logic              gie,
   output logic              vec_load,
   output logic              ret_push,
   output logic              rest_load,
   output logic [DATA_W-1:0] rest_w,
   output logic [DATA_W-1:0] rest_status,
   output logic [DATA_W-1:0] rest_bsr
);

   localparam int unsigned NREG     = 3;
   localparam int unsigned VEC_CLK  = irqe_clocks(LAT_CYC, PHASES);
   localparam int unsigned PUSH_CLK = PHASES;
   localparam int unsigned CNT_W    = $clog2(VEC_CLK + 1);

   if (PHASES < 2 || PH_W != $clog2(PHASES)) begin : g_bad_phase
      $error("PHASES must be at least 2 and PH_W must equal clog2(PHASES)");
   end
   if (LAT_CYC < 2) begin : g_bad_lat
      $error("LAT_CYC must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("DATA_W must be positive");
   end

   logic                   cyc_start, ext_rise, save;
   logic [NREG*DATA_W-1:0] live_state, saved_state;

   irqe_phase_gen #(.PHASES(PHASES), .PH_W(PH_W)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase     (cyc_phase),
      .cyc_start (cyc_start)
   );

   irqe_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ext_irq),
      .rise     (ext_rise)
   );

   irqe_entry_seq #(.VEC_CLK(VEC_CLK), .PUSH_CLK(PUSH_CLK), .CW(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cyc_start (cyc_start),
      .int_irq   (int_irq),
      .ext_rise  (ext_rise),
      .gie_we    (gie_we),
      .gie_wdata (gie_wdata),
      .reti      (reti),
      .save      (save),
      .gie       (gie),
      .vec_load  (vec_load),
      .ret_push  (ret_push),
      .rest_load (rest_load)
   );

   assign live_state = {core_bsr, core_status, core_w};

   irqe_shadow #(.DW(DATA_W), .NREG(NREG)) u_shadow (
      .clk   (clk),
      .rst_n (rst_n),
      .save  (save),
      .live  (live_state),
      .saved (saved_state)
   );

   assign rest_w      = saved_state[0*DATA_W +: DATA_W];
   assign rest_status = saved_state[1*DATA_W +: DATA_W];
   assign rest_bsr    = saved_state[2*DATA_W +: DATA_W];

   a_r7_shadow_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!save) |=> $stable(saved_state));

endmodule

// File: tb/test_irq_entry_ctrl.sv
module test_irq_entry_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_irq = 1'b0, int_irq = 1'b0, gie_we = 1'b0, gie_wdata = 1'b0, reti = 1'b0;
   logic [7:0] core_w = 8'h3C, core_status = 8'hA5, core_bsr = 8'h17;
   logic [1:0] cyc_phase;
   logic       gie, vec_load, ret_push, rest_load;
   logic [7:0] rest_w, rest_status, rest_bsr;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  flip_core = 1'b0;
   bit  done = 1'b0;
   int  n_vec, n_push, n_rest;

   always #10 clk = ~clk;

   irq_entry_ctrl i_irq_entry_ctrl (
      .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .int_irq(int_irq),
      .gie_we(gie_we), .gie_wdata(gie_wdata), .reti(reti),
      .core_w(core_w), .core_status(core_status), .core_bsr(core_bsr),
      .cyc_phase(cyc_phase), .gie(gie), .vec_load(vec_load), .ret_push(ret_push),
      .rest_load(rest_load), .rest_w(rest_w), .rest_status(rest_status), .rest_bsr(rest_bsr)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_phase(input int p);
      do @(negedge clk); while (cyc_phase != 2'(p));
   endtask

   task automatic set_gie(input bit v);
      @(negedge clk); gie_we = 1'b1; gie_wdata = v;
      @(negedge clk); gie_we = 1'b0;
   endtask

   // Counts falling edges after the current drive until vec_load is seen
   task automatic run_to_vec();
      int n = 0;
      n_push = -1; n_rest = -1;
      do begin
         @(negedge clk);
         n++;
         if (n == 1) begin int_irq = 1'b0; gie_we = 1'b0; reti = 1'b0; end
         if (n == 2 && flip_core) begin
            core_w = ~core_w; core_status = ~core_status; core_bsr = ~core_bsr;
         end
         if (ret_push && n_push < 0) n_push = n;
         if (rest_load && n_rest < 0) n_rest = n;
      end while (!vec_load && n < 60);
      n_vec = n;
   endtask

   task automatic do_reti(input string req, input logic [7:0] ew, es, eb);
      @(negedge clk); reti = 1'b1;
      @(negedge clk); reti = 1'b0;
      check({req, " rest_load"}, int'(rest_load), 1);
      check({req, " rest_w"}, int'(rest_w), int'(ew));
      check({req, " rest_status"}, int'(rest_status), int'(es));
      check({req, " rest_bsr"}, int'(rest_bsr), int'(eb));
      check({req, " gie after reti"}, int'(gie), 1);
      @(negedge clk);
      check({req, " rest_load single"}, int'(rest_load), 0);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check("R1 gie", int'(gie), 0);
      check("R1 vec_load", int'(vec_load), 0);
      check("R1 ret_push", int'(ret_push), 0);
      check("R1 rest_load", int'(rest_load), 0);
      check("R1 rest regs", int'({rest_w, rest_status, rest_bsr}), 0);
      check("R1 phase", int'(cyc_phase), 0);
      rst_n = 1'b1;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         check("R2 phase sequence", int'(cyc_phase), (i + 1) % 4);
      end
   endtask

   task automatic t_int_latency();
      logic [7:0] sw, ss, sb;
      set_gie(1'b1);
      wait_phase(0);
      sw = core_w; ss = core_status; sb = core_bsr;
      int_irq = 1'b1;
      flip_core = 1'b1;
      run_to_vec();
      flip_core = 1'b0;
      check("R3 internal latency", n_vec, 12);
      check("R4 push offset", n_push, 4);
      check("R3 vec on phase 0", int'(cyc_phase), 0);
      check("R6 gie cleared at entry", int'(gie), 0);
      do_reti("R7 R8 restore after change", sw, ss, sb);
   endtask

   task automatic t_int_phase();
      for (int p = 1; p < 4; p++) begin
         wait_phase(p);
         int_irq = 1'b1;
         run_to_vec();
         check("R10 late-phase internal latency", n_vec, 12 + (4 - p));
         do_reti("R10 restore", core_w, core_status, core_bsr);
      end
   endtask

   task automatic t_ext();
      int extra;
      repeat (6) @(negedge clk);
      for (int p = 0; p < 4; p++) begin
         wait_phase(p);
         ext_irq = 1'b1;
         run_to_vec();
         // second flop holds the level from edge 2; rise seen in phase (p+2)%4
         check("R5 external latency", n_vec, 14 + ((4 - ((p + 2) % 4)) % 4));
         do_reti("R5 restore", core_w, core_status, core_bsr);
         extra = 0;
         repeat (20) begin @(negedge clk); if (vec_load) extra++; end
         check("R5 held level no re-entry", extra, 0);
         ext_irq = 1'b0;
         repeat (6) @(negedge clk);
      end
   endtask

   task automatic t_gie_pend();
      int seen = 0;
      int pa;
      set_gie(1'b0);
      wait_phase(0);
      int_irq = 1'b1;
      @(negedge clk); int_irq = 1'b0;
      repeat (20) begin @(negedge clk); if (vec_load) seen++; end
      check("R6 no entry while gie=0", seen, 0);
      pa = int'(cyc_phase);
      gie_we = 1'b1; gie_wdata = 1'b1;
      run_to_vec();
      check("R6 pending taken after enable", n_vec, 13 + ((4 - ((pa + 1) % 4)) % 4));
      do_reti("R6 restore", core_w, core_status, core_bsr);
   endtask

   task automatic t_nested();
      int seen = 0;
      int pr;
      logic [7:0] sw, ss, sb;
      wait_phase(0);
      sw = core_w; ss = core_status; sb = core_bsr;
      int_irq = 1'b1;
      run_to_vec();
      check("R9 first entry", n_vec, 12);
      @(negedge clk); int_irq = 1'b1;
      @(negedge clk); int_irq = 1'b0;
      repeat (10) begin @(negedge clk); if (vec_load) seen++; end
      check("R9 no entry during service", seen, 0);
      pr = int'(cyc_phase);
      reti = 1'b1;
      run_to_vec();
      check("R9 restore strobe", n_rest, 1);
      check("R9 pending taken after reti", n_vec, 13 + ((4 - ((pr + 1) % 4)) % 4));
      do_reti("R9 second restore", sw, ss, sb);
   endtask

   task automatic t_reti_idle();
      int seen = 0;
      set_gie(1'b0);
      @(negedge clk); reti = 1'b1;
      @(negedge clk); reti = 1'b0;
      check("R8 idle reti no restore", int'(rest_load), 0);
      check("R8 idle reti gie unchanged", int'(gie), 0);
      repeat (4) begin @(negedge clk); if (rest_load) seen++; end
      check("R8 idle reti quiet", seen, 0);
      set_gie(1'b1);
   endtask

   initial begin
      t_reset();
      t_int_latency();
      t_int_phase();
      t_ext();
      t_gie_pend();
      t_nested();
      t_reti_idle();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule